// File: doc/BRIEF.md
# Packed SIMD Video ALU

This block is a single-cycle packed arithmetic unit for pixel and sample processing. It takes two 32-bit operand words. Depending on the opcode, it treats each word either as a pair of signed 16-bit halves or as four unsigned 8-bit bytes. Every lane is computed on its own, and each lane clips or saturates without reference to its neighbours.

The unit supports:
- paired 16-bit add and subtract, with optional signed saturation;
- byte add clamped to the unsigned byte range;
- a rounded byte average;
- a fused byte subtract, absolute value and accumulate step, used for block-matching cost.

The fused step feeds two persistent 16-bit accumulators. Those accumulators keep their value across operations until a clear input zeroes them.

An operation is presented with `opValid` for one cycle. The result, the per-half overflow flags and the accumulator values are registered and appear one clock later together with `resValid`.

Top module: `simd_video_alu`

## Requirements
- R1: When `opValid` is high at a rising edge, `resValid` is high during the following cycle. When `opValid` is low, `resValid` is low and `result`, `ovfHi` and `ovfLo` hold their previous values.
- R2: Opcode 0 adds the upper halves (bits 31:16) and the lower halves (bits 15:0) as independent 16-bit lanes. No carry passes between the halves, and with `satEn` low each half wraps modulo 2^16.
- R3: Opcode 1 subtracts `srcB` from `srcA` per 16-bit half, with the same lane independence and wrapping as R2.
- R4: For opcodes 0 and 1, `ovfHi` and `ovfLo` report signed 16-bit overflow of the upper and lower half, whatever the value of `satEn`. With `satEn` high, an overflowing half is clamped to 0x7FFF (positive overflow) or 0x8000 (negative overflow). Every other opcode clears both flags.
- R5: Opcode 2 adds the four unsigned bytes lane by lane and clamps each lane sum to 255.
- R6: Opcode 3 gives, per byte lane, (a + b + 1) >> 1 using unsigned arithmetic, so exact halves round up.
- R7: Opcode 4 adds |a-b| of bytes 0 and 1 (bits 15:0) to `accA`, and |a-b| of bytes 2 and 3 (bits 31:16) to `accB`. `result` takes {new `accB`, new `accA`}. No other opcode changes the accumulators.
- R8: Each accumulator saturates at 0xFFFF and never wraps.
- R9: `sadClear` zeroes both accumulators at the next edge whether or not an operation is valid. When it coincides with opcode 4, the clear wins and `result` reads 0.
- R10: Opcodes 5 to 7 produce `result` 0 with both overflow flags 0, still assert `resValid`, and leave the accumulators unchanged.
- R11: While `rstN` is low, `resValid`, `result`, the flags and both accumulators are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 3 | Operation select (0..4 defined) |
| srcA | input | 32 | First packed operand |
| srcB | input | 32 | Second packed operand |
| satEn | input | 1 | Saturate 16-bit halves on overflow |
| sadClear | input | 1 | Zero both accumulators |
| resValid | output | 1 | Result registered this cycle |
| result | output | 32 | Packed result |
| ovfHi | output | 1 | Signed overflow of upper half |
| ovfLo | output | 1 | Signed overflow of lower half |
| accA | output | 16 | Accumulator for bytes 0 and 1 |
| accB | output | 16 | Accumulator for bytes 2 and 3 |

## Verification
The bench uses operands where the lower half carries out while the upper half overflows. A design that chains the halves would corrupt the upper lane, and one that applies saturation to the wrong half would clamp a lane that did not overflow.

Byte clipping is driven with sums of exactly 256 and 255, and averaging with odd sums, to catch a clamp that is off by one and an average that truncates.

The accumulators are run well past 0xFFFF, so a wrapping accumulator shows a small value. A clear that arrives together with an accumulate step must leave zeros, not the fresh sample. Undefined opcodes must neither disturb the accumulators nor leave stale flags set.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD16 = 3'd0,
    OP_SUB16 = 3'd1,
    OP_CLIPB = 3'd2,
    OP_AVGB  = 3'd3,
    OP_SADB  = 3'd4
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic add16;
    logic sub16;
    logic clip8;
    logic avg8;
    logic sad;
    logic satOn;
    logic accClr;
  } aluStrobe_t;

endpackage

// File: rtl/simd_alu_ctrl.sv
module simd_alu_ctrl
  import simd_alu_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       satEn,
  input  logic       sadClear,
  output aluStrobe_t stb
);

  always_comb begin
    stb        = '0;
    stb.load   = opValid;
    stb.satOn  = satEn;
    stb.accClr = sadClear;
    if (opValid) begin
      unique case (opCode)
        OP_ADD16: stb.add16 = 1'b1;
        OP_SUB16: stb.sub16 = 1'b1;
        OP_CLIPB: stb.clip8 = 1'b1;
        OP_AVGB:  stb.avg8  = 1'b1;
        OP_SADB:  stb.sad   = 1'b1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/simd_alu_dp.sv
module simd_alu_dp
  import simd_alu_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  aluStrobe_t            stb,
  input  logic [4*LANE_W-1:0]   srcA,
  input  logic [4*LANE_W-1:0]   srcB,
  output logic                  resValid,
  output logic [4*LANE_W-1:0]   result,
  output logic                  ovfHi,
  output logic                  ovfLo,
  output logic [2*LANE_W-1:0]   accA,
  output logic [2*LANE_W-1:0]   accB
);

  localparam int HALF_W  = 2 * LANE_W;
  localparam int WORD_W  = 4 * LANE_W;
  localparam int N_HALF  = 2;
  localparam int N_LANE  = 4;
  localparam logic [HALF_W-1:0] HALF_MAX = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] HALF_MIN = {1'b1, {(HALF_W-1){1'b0}}};

  logic [WORD_W-1:0] halfWord;
  logic [WORD_W-1:0] clipWord;
  logic [WORD_W-1:0] avgWord;
  logic [N_HALF-1:0] halfOvf;
  logic [LANE_W-1:0] absDiff [N_LANE];
  logic [HALF_W-1:0] accNext [N_HALF];
  logic [HALF_W-1:0] accCur  [N_HALF];

  assign accCur[0] = accA;
  assign accCur[1] = accB;

  // 16-bit half lanes
  for (genvar g = 0; g < N_HALF; g++) begin : gHalf
    logic [HALF_W-1:0] aH, bH, hOut;
    logic [HALF_W:0]   aX, bX, hRaw;
    logic              hOvf;
    assign aH   = srcA[g*HALF_W +: HALF_W];
    assign bH   = srcB[g*HALF_W +: HALF_W];
    assign aX   = {aH[HALF_W-1], aH};
    assign bX   = {bH[HALF_W-1], bH};
    assign hRaw = stb.sub16 ? (aX - bX) : (aX + bX);
    assign hOvf = hRaw[HALF_W] ^ hRaw[HALF_W-1];
    always_comb begin
      if (hOvf && stb.satOn) hOut = hRaw[HALF_W] ? HALF_MIN : HALF_MAX;
      else                   hOut = hRaw[HALF_W-1:0];
    end
    assign halfWord[g*HALF_W +: HALF_W] = hOut;
    assign halfOvf[g] = hOvf;
  end

  // 8-bit byte lanes
  for (genvar k = 0; k < N_LANE; k++) begin : gLane
    logic [LANE_W-1:0] aB, bB;
    logic [LANE_W:0]   bSum, bSumR;
    assign aB    = srcA[k*LANE_W +: LANE_W];
    assign bB    = srcB[k*LANE_W +: LANE_W];
    assign bSum  = {1'b0, aB} + {1'b0, bB};
    assign bSumR = bSum + {{LANE_W{1'b0}}, 1'b1};
    assign clipWord[k*LANE_W +: LANE_W] = bSum[LANE_W] ? {LANE_W{1'b1}} : bSum[LANE_W-1:0];
    assign avgWord[k*LANE_W +: LANE_W]  = bSumR[LANE_W:1];
    assign absDiff[k] = (aB >= bB) ? (aB - bB) : (bB - aB);
  end

  // accumulator pairs: lanes 2j and 2j+1 feed accumulator j
  for (genvar j = 0; j < N_HALF; j++) begin : gAcc
    logic [LANE_W:0] pairSum;
    logic [HALF_W:0] accSum;
    assign pairSum = {1'b0, absDiff[2*j]} + {1'b0, absDiff[2*j+1]};
    assign accSum  = {1'b0, accCur[j]} + {{(HALF_W-LANE_W){1'b0}}, pairSum};
    assign accNext[j] = accSum[HALF_W] ? {HALF_W{1'b1}} : accSum[HALF_W-1:0];
  end

  logic [WORD_W-1:0] nextWord;
  logic [N_HALF-1:0] nextOvf;

  always_comb begin
    nextWord = '0;
    nextOvf  = '0;
    if (stb.add16 || stb.sub16) begin
      nextWord = halfWord;
      nextOvf  = halfOvf;
    end else if (stb.clip8) begin
      nextWord = clipWord;
    end else if (stb.avg8) begin
      nextWord = avgWord;
    end else if (stb.sad && !stb.accClr) begin
      nextWord = {accNext[1], accNext[0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      result   <= '0;
      ovfHi    <= 1'b0;
      ovfLo    <= 1'b0;
      accA     <= '0;
      accB     <= '0;
    end else begin
      resValid <= stb.load;
      if (stb.load) begin
        result <= nextWord;
        ovfHi  <= nextOvf[1];
        ovfLo  <= nextOvf[0];
      end
      if (stb.accClr) begin
        accA <= '0;
        accB <= '0;
      end else if (stb.sad) begin
        accA <= accNext[0];
        accB <= accNext[1];
      end
    end
  end

endmodule

// File: rtl/simd_video_alu.sv
module simd_video_alu
  import simd_alu_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [2:0]          opCode,
  input  logic [4*LANE_W-1:0] srcA,
  input  logic [4*LANE_W-1:0] srcB,
  input  logic                satEn,
  input  logic                sadClear,
  output logic                resValid,
  output logic [4*LANE_W-1:0] result,
  output logic                ovfHi,
  output logic                ovfLo,
  output logic [2*LANE_W-1:0] accA,
  output logic [2*LANE_W-1:0] accB
);

  aluStrobe_t stb;

  simd_alu_ctrl uCtrl (
    .opValid  (opValid),
    .opCode   (opCode),
    .satEn    (satEn),
    .sadClear (sadClear),
    .stb      (stb)
  );

  simd_alu_dp #(.LANE_W(LANE_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .srcA     (srcA),
    .srcB     (srcB),
    .resValid (resValid),
    .result   (result),
    .ovfHi    (ovfHi),
    .ovfLo    (ovfLo),
    .accA     (accA),
    .accB     (accB)
  );

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                opValid,
  input logic [2:0]          opCode,
  input logic                satEn,
  input logic                sadClear,
  input logic                resValid,
  input logic [4*LANE_W-1:0] result,
  input logic                ovfHi,
  input logic                ovfLo,
  input logic [2*LANE_W-1:0] accA,
  input logic [2*LANE_W-1:0] accB
);

  localparam int HALF_W = 2 * LANE_W;
  localparam logic [HALF_W-1:0] POS_LIM = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] NEG_LIM = {1'b1, {(HALF_W-1){1'b0}}};

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resValid && $stable(result) && $stable(ovfHi) && $stable(ovfLo))); // R1
  AST_FLAGS_ONLY_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode >= 3'd2) |=> (!ovfHi && !ovfLo)); // R4
  AST_SAT_CLAMP_HI: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && satEn && opCode <= 3'd1) |=>
      (!ovfHi || result[2*HALF_W-1:HALF_W] == POS_LIM || result[2*HALF_W-1:HALF_W] == NEG_LIM)); // R4
  AST_SAT_CLAMP_LO: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && satEn && opCode <= 3'd1) |=>
      (!ovfLo || result[HALF_W-1:0] == POS_LIM || result[HALF_W-1:0] == NEG_LIM)); // R4
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sadClear && !(opValid && opCode == 3'd4)) |=> ($stable(accA) && $stable(accB))); // R7
  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !sadClear |=> (accA >= $past(accA) && accB >= $past(accB))); // R8
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    sadClear |=> (accA == '0 && accB == '0)); // R9

endmodule

bind simd_video_alu simd_alu_chk #(.LANE_W(LANE_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .satEn    (satEn),
  .sadClear (sadClear),
  .resValid (resValid),
  .result   (result),
  .ovfHi    (ovfHi),
  .ovfLo    (ovfLo),
  .accA     (accA),
  .accB     (accB)
);

// File: tb/sim_simd_video_alu.sv
`timescale 1ns/1ps
module sim_simd_video_alu;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [2:0]  opCode;
  logic [31:0] srcA, srcB;
  logic        satEn, sadClear;
  logic        resValid;
  logic [31:0] result;
  logic        ovfHi, ovfLo;
  logic [15:0] accA, accB;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  simd_video_alu u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .satEn(satEn), .sadClear(sadClear),
    .resValid(resValid), .result(result), .ovfHi(ovfHi), .ovfLo(ovfLo),
    .accA(accA), .accB(accB)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one op at a falling edge, release at the next; outputs are settled then
  task automatic runOp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sat, input logic clr, input logic vld);
    @(negedge clk);
    opValid = vld; opCode = op; srcA = a; srcB = b; satEn = sat; sadClear = clr;
    @(negedge clk);
    opValid = 1'b0; sadClear = 1'b0;
  endtask

  task automatic tReset();
    check("R11 resValid", {31'b0, resValid}, 32'h0);
    check("R11 result", result, 32'h0);
    check("R11 acc", {accB, accA}, 32'h0);
    check("R11 flags", {30'b0, ovfHi, ovfLo}, 32'h0);
  endtask

  task automatic tAdd16();
    runOp(3'd0, 32'h7FFF_0001, 32'h0001_FFFF, 1'b0, 1'b0, 1'b1);
    check("R1 valid", {31'b0, resValid}, 32'h1);
    check("R2 wrap no carry", result, 32'h8000_0000);
    check("R4 flags add wrap", {30'b0, ovfHi, ovfLo}, 32'h2);
    @(negedge clk);
    check("R1 idle valid", {31'b0, resValid}, 32'h0);
    check("R1 idle hold", result, 32'h8000_0000);
    runOp(3'd0, 32'h7FFF_0001, 32'h0001_FFFF, 1'b1, 1'b0, 1'b1);
    check("R4 add sat", result, 32'h7FFF_0000);
    runOp(3'd0, 32'h1234_8000, 32'h1111_8000, 1'b1, 1'b0, 1'b1);
    check("R4 add sat low neg", result, 32'h2345_8000);
    check("R4 flags low", {30'b0, ovfHi, ovfLo}, 32'h1);
  endtask

  task automatic tSub16();
    runOp(3'd1, 32'h8000_0005, 32'h0001_0007, 1'b1, 1'b0, 1'b1);
    check("R3 R4 sub sat", result, 32'h8000_FFFE);
    check("R4 sub flags", {30'b0, ovfHi, ovfLo}, 32'h2);
    runOp(3'd1, 32'h8000_0005, 32'h0001_0007, 1'b0, 1'b0, 1'b1);
    check("R3 sub wrap", result, 32'h7FFF_FFFE);
  endtask

  task automatic tClip();
    runOp(3'd2, 32'hFF80_1001, 32'h0180_20FE, 1'b0, 1'b0, 1'b1);
    check("R5 clip", result, 32'hFFFF_30FF);
    check("R4 flags cleared", {30'b0, ovfHi, ovfLo}, 32'h0);
    runOp(3'd2, 32'h1234_5678, 32'h0101_0101, 1'b0, 1'b0, 1'b1);
    check("R5 no clip", result, 32'h1335_5779);
  endtask

  task automatic tAvg();
    runOp(3'd3, 32'h00FF_0301, 32'h01FF_0402, 1'b0, 1'b0, 1'b1);
    check("R6 avg round", result, 32'h01FF_0402);
    runOp(3'd3, 32'h0A00_FE10, 32'h0B01_FF20, 1'b0, 1'b0, 1'b1);
    check("R6 avg mix", result, 32'h0B01_FF18);
  endtask

  task automatic tSad();
    runOp(3'd7, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0);
    check("R9 clear alone", {accB, accA}, 32'h0);
    runOp(3'd4, 32'h1020_3040, 32'h2010_4030, 1'b0, 1'b0, 1'b1);
    check("R7 sad result", result, 32'h0020_0020);
    check("R7 sad acc", {accB, accA}, 32'h0020_0020);
    runOp(3'd4, 32'h0000_0005, 32'h0300_0000, 1'b0, 1'b0, 1'b1);
    check("R7 sad accum", {accB, accA}, 32'h0023_0025);
    runOp(3'd0, 32'h1111_1111, 32'h2222_2222, 1'b0, 1'b0, 1'b1);
    check("R7 acc held by add", {accB, accA}, 32'h0023_0025);
    runOp(3'd5, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b1);
    check("R10 undefined result", result, 32'h0);
    check("R10 undefined valid", {31'b0, resValid}, 32'h1);
    check("R10 undefined acc", {accB, accA}, 32'h0023_0025);
    check("R10 undefined flags", {30'b0, ovfHi, ovfLo}, 32'h0);
    runOp(3'd4, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1, 1'b1);
    check("R9 clear wins acc", {accB, accA}, 32'h0);
    check("R9 clear wins result", result, 32'h0);
  endtask

  task automatic tSadSat();
    for (int i = 0; i < 140; i++) begin
      @(negedge clk);
      opValid = 1'b1; opCode = 3'd4; srcA = 32'hFFFF_FFFF; srcB = 32'h0; sadClear = 1'b0;
    end
    @(negedge clk);
    opValid = 1'b0;
    check("R8 acc saturate", {accB, accA}, 32'hFFFF_FFFF);
    check("R8 result saturate", result, 32'hFFFF_FFFF);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; opValid = 1'b0; opCode = '0; srcA = '0; srcB = '0;
    satEn = 1'b0; sadClear = 1'b0;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    tAdd16();
    tSub16();
    tClip();
    tAvg();
    tSad();
    tSadSat();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule